// File: doc/BRIEF.md
# Byte-to-Residue Digit Converter

This block turns an unsigned 8-bit sample into its digits in a residue number system whose moduli are 13, 11, 9, 7, 5 and 4. It is the input stage of a residue-arithmetic image filter. A 3x3 window brings in three fresh samples every clock, one from each covered row, so the filter holds three copies of this converter.

The byte is split into two nibbles, and each one goes through its own small 16-entry table for each modulus. The high-nibble table already carries the weight sixteen reduced modulo m, and the low-nibble table reduces the nibble itself. One modular adder then merges the two partial digits. Both partial digits are already below m, so a single conditional subtraction is enough. The modulus-4 digit needs no table because it is the two lowest bits of the sample. A parameter chooses whether the packed output goes through a register, which is the default, or leaves the block combinationally.

Top module: `byte_residue_conv`

## Requirements
- R1: The output holds, in 4-bit fields, the sample modulo 13 in bits [23:20], modulo 11 in [19:16], modulo 9 in [15:12], modulo 7 in [11:8] and modulo 5 in [7:4].
- R2: Every field is always strictly less than its own modulus.
- R3: Bits [3:0] hold the sample modulo 4: bits [1:0] copy sample bits [1:0] and bits [3:2] are zero.
- R4: With the output register enabled (the default), the output changes one rising clock edge after the sample is applied and reflects the sample seen at that edge.
- R5: While the active-low synchronous reset is asserted, the registered output is all zeros.
- R6: While the sample is held steady, the output does not change.
- R7: Boundary cases give the exact digits: sample 0 gives all zeros, 255 gives 8,2,3,3,0,3, and 26 gives 0 for modulus 13, where the two partial digits sum to exactly 13.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset |
| sample | input | 8 | Unsigned binary sample |
| residues | output | 24 | Packed residue digits, six 4-bit fields |

## Verification
A wrong table entry shows up only for the sample values whose nibble selects that entry. It then appears at the port one edge later as a digit that differs from the sample modulo m. For this reason every one of the 256 samples is applied and all six fields are compared. A broken modular-adder threshold either produces a digit at or above m, which the range property catches on the next edge, or leaves a sum one modulus too small. Sample 26 and the full sweep expose the second case. A wrong register or reset behaviour shows as a stale or non-zero field within one cycle of the stimulus.

// File: rtl/byte_residue_conv.sv
module byte_residue_conv #(
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  sample,
  output logic [23:0] residues
);
  localparam int NMOD = 5;
  localparam int FW   = 4;
  localparam int TBITS = 16 * FW;

  function automatic int modulus(int k);
    case (k)
      0: return 13;
      1: return 11;
      2: return 9;
      3: return 7;
      default: return 5;
    endcase
  endfunction

  function automatic logic [TBITS-1:0] hi_table(int m);
    logic [TBITS-1:0] t = '0;
    for (int i = 0; i < 16; i++) t[i*FW +: FW] = FW'((i * (16 % m)) % m);
    return t;
  endfunction

  function automatic logic [TBITS-1:0] lo_table(int m);
    logic [TBITS-1:0] t = '0;
    for (int i = 0; i < 16; i++) t[i*FW +: FW] = FW'(i % m);
    return t;
  endfunction

  logic [23:0] conv;

  for (genvar k = 0; k < NMOD; k++) begin : g_mod
    localparam int M = modulus(k);
    localparam logic [TBITS-1:0] HT = hi_table(M);
    localparam logic [TBITS-1:0] LT = lo_table(M);
    logic [FW-1:0] hp, lp;
    logic [FW:0]   sum;
    assign hp  = HT[{sample[7:4], 2'b00} +: FW];
    assign lp  = LT[{sample[3:0], 2'b00} +: FW];
    assign sum = {1'b0, hp} + {1'b0, lp};
    assign conv[23-FW*k -: FW] = (sum >= (FW+1)'(M)) ? FW'(sum - (FW+1)'(M)) : sum[FW-1:0];
  end

  assign conv[3:0] = {2'b00, sample[1:0]};

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) residues <= '0;
      else        residues <= conv;
    end
  end else begin : g_comb
    assign residues = conv;
  end
endmodule

// File: rtl/byte_residue_conv_chk.sv
module byte_residue_conv_chk #(
  parameter bit OUT_REG = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  sample,
  input logic [23:0] residues
);
  p_digit_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    residues[23:20] < 4'd13 && residues[19:16] < 4'd11 && residues[15:12] < 4'd9 &&
    residues[11:8] < 4'd7 && residues[7:4] < 4'd5 && residues[3:0] < 4'd4);

  if (OUT_REG) begin : g_seq
    p_mod4_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> residues[3:0] == {2'b00, $past(sample[1:0])});

    p_one_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> residues[23:20] == 4'($past(sample) % 8'd13));

    p_mod7_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> residues[11:8] == 4'($past(sample) % 8'd7));

    p_reset_zero_r5: assert property (@(posedge clk)
      !rst_n |=> residues == 24'd0);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $stable(sample) |=> $stable(residues));
  end
endmodule

bind byte_residue_conv byte_residue_conv_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample(sample), .residues(residues)
);

// File: tb/tb_byte_residue_conv.sv
module tb_byte_residue_conv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sample = 8'd0;
  logic [23:0] residues;
  int checks = 0;
  int failures = 0;

  byte_residue_conv dut (.clk(clk), .rst_n(rst_n), .sample(sample), .residues(residues));

  always #5 clk = ~clk;

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] expect_of(logic [7:0] x);
    int v = x;
    return {4'(v % 13), 4'(v % 11), 4'(v % 9), 4'(v % 7), 4'(v % 5), 4'(v % 4)};
  endfunction

  task automatic apply(logic [7:0] v);
    @(negedge clk);
    sample = v;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    sample = 8'd77;
    repeat (3) @(negedge clk);
    check("R5 reset", residues, 24'd0);
    rst_n = 1'b1;

    for (int x = 0; x < 256; x++) begin
      apply(8'(x));
      check("R1 mod13", {20'd0, residues[23:20]}, {20'd0, expect_of(8'(x))[23:20]});
      check("R1 mod11", {20'd0, residues[19:16]}, {20'd0, expect_of(8'(x))[19:16]});
      check("R1 mod9",  {20'd0, residues[15:12]}, {20'd0, expect_of(8'(x))[15:12]});
      check("R1 mod7",  {20'd0, residues[11:8]},  {20'd0, expect_of(8'(x))[11:8]});
      check("R1 mod5",  {20'd0, residues[7:4]},   {20'd0, expect_of(8'(x))[7:4]});
      check("R3 mod4",  {20'd0, residues[3:0]},   {22'd0, 2'(x)});
      check("R2 range", {23'd0, residues[23:20] < 13 && residues[19:16] < 11 &&
            residues[15:12] < 9 && residues[11:8] < 7 && residues[7:4] < 5 && residues[3:0] < 4},
            24'd1);
    end

    apply(8'd0);   check("R7 zero", residues, 24'h000000);
    apply(8'd255); check("R7 max",  residues, 24'h823303);
    apply(8'd26);  check("R7 sum equals modulus", {20'd0, residues[23:20]}, 24'd0);

    apply(8'd100);
    @(negedge clk);
    sample = 8'd200;
    #1 check("R4 before edge", residues, expect_of(8'd100));
    @(negedge clk);
    check("R4 after edge", residues, expect_of(8'd200));

    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R6 held", residues, expect_of(8'd200));
    end

    rst_n = 1'b0;
    @(negedge clk);
    check("R5 reset again", residues, 24'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule